// File: doc/BRIEF.md
# Dual-Strobe Byte-Lane DRAM Front-End

This block is a synthesizable, sampled-signal model of the control front-end of an asynchronous sixteen-bit dynamic memory. A fast system clock samples the active-low row strobe, the two byte-lane column strobes, the write-select and output-enable pins, and a nine-bit multiplexed address bus. All of these pins, and the data-in bus, pass through a chain of synchronizer flops. Edges are found by comparing the newest synchronized sample with the one before it.

The row address is taken when the row strobe falls. The column path then follows the address bus freely. It freezes on whichever column strobe falls first, and it reopens only once both column strobes are high again. Each column strobe enables its own byte of the data bus. Both bytes use the one latched column, so a cell can be read or written a byte at a time.

A write chosen before the first column strobe falls is an early write. It masks the write by byte lane and never drives the bus. A read drives only the lanes whose strobe is low, and only while output-enable is asserted. The storage behind the block is a small array. Its location is formed from folded row and column bits whose widths are parameters. The data bus is modelled as separate input, output and per-lane drive-enable signals.

Top module: `dram_dualcas_frontend`

## Requirements
- R1: The row address is taken from the address bus on the falling edge of ras_n, and the column address on the first falling edge of either CAS. With the default parameters and address bits above bit 1 (row) and bit 3 (column) held at zero, the storage location is row*16 + column, so every one of the 64 row/column pairs holds its own 16-bit word.
- R2: dq_oe[0] and dq_out[7:0] belong to lcas_n, and dq_oe[1] and dq_out[15:8] belong to ucas_n. A lane is never driven while its own strobe is high, and an undriven lane reads as zero on dq_out.
- R3: After ras_n falls, and while both CAS are high, the column path follows the address bus. The column actually used is the address present when the first CAS falls, not any earlier value on the bus.
- R4: While at least one CAS is low, address changes are ignored. A strobe falling while the other is still low uses the column already latched. A new column is taken only after both strobes have been high.
- R5: Each CAS falling on its own enables only its own lane, with that lane's byte of the word at the single latched column.
- R6: If we_n is low when the first CAS falls (early write), dq_oe stays 00 for the whole column cycle, even with oe_n low.
- R7: A lane is driven only while ras_n is low, that lane's CAS is low, we_n is high and oe_n is low. Raising oe_n, or pulling we_n low after a read has started, turns the drive off and writes nothing.
- R8: An early write takes its data on the first CAS fall. It writes only the lanes whose CAS goes low in that column cycle, and a lane whose strobe falls later in the same cycle receives the data captured at the first fall. The other lane and all other columns keep their contents.
- R9: While ras_n stays low, any number of CAS cycles may reach different columns of the open row without a new row cycle.
- R10: After reset, and from the cycle after ras_n is seen high, dq_oe is 00 and dq_out is zero, and the column latch is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write select: low writes, high reads |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Data bus as seen by the device |
| dq_out | output | 16 | Data the device drives, zero in undriven lanes |
| dq_oe | output | 2 | Per-lane drive enable: bit 0 lower byte, bit 1 upper byte |

## Verification
Some properties are checked on every cycle. These are: the row word held steady while the row is open, the column frozen while either strobe is low, each lane silent while its own strobe or the output enable is high, an early-write cycle never driving, and all lanes quiet once the row strobe is high.

Other behaviours can only be shown by the bench's scenarios. These include whether the right data landed in the right cell under byte masking, and which address a transparent column actually took at the strobe edge. They also include the reuse of the latched column by a lagging strobe, a late lane being written with first-edge data, and page-mode sweeps across every row and column.

// File: rtl/dram_fe_pkg.sv
package dram_fe_pkg;

   typedef struct packed {
      logic ras_n;
      logic lcas_n;
      logic ucas_n;
      logic we_n;
      logic oe_n;
   } ctl_pins_t;

   localparam int CTL_W = $bits(ctl_pins_t);

endpackage

// File: rtl/dram_fe_sync.sv
module dram_fe_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dram_fe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[g] <= RST_VAL;
         end else if (g == 0) begin
            stg[g] <= din;
         end else begin
            stg[g] <= stg[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/dram_fe_addr_latch.sv
module dram_fe_addr_latch #(
   parameter int ADDR_W = 9,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_ras_n,
   input  logic [LANES-1:0]  s_cas_n,
   input  logic              s_we_n,
   input  logic [ADDR_W-1:0] s_addr,
   output logic              row_open,
   output logic [ADDR_W-1:0] row_q,
   output logic              col_held,
   output logic [ADDR_W-1:0] col_q,
   output logic              wr_q,
   output logic [ADDR_W-1:0] col_eff,
   output logic              wr_eff
);

   logic ras_fall;
   logic held_d;
   logic first_cas;

   assign ras_fall  = ~s_ras_n & ~row_open;
   assign held_d    = row_open & ~s_ras_n & (|(~s_cas_n));
   assign first_cas = held_d & ~col_held;
   assign col_eff   = col_held ? col_q : s_addr;
   assign wr_eff    = col_held ? wr_q  : ~s_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open <= 1'b0;
         row_q    <= '0;
         col_held <= 1'b0;
         col_q    <= '0;
         wr_q     <= 1'b0;
      end else begin
         row_open <= ~s_ras_n;
         col_held <= held_d;
         if (ras_fall) begin
            row_q <= s_addr;
         end
         if (first_cas) begin
            col_q <= s_addr;
            wr_q  <= ~s_we_n;
         end
      end
   end

endmodule

// File: rtl/dram_fe_lane_store.sv
module dram_fe_lane_store #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   parameter int IDX_W  = 6
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        we_lane,
   input  logic [IDX_W-1:0]        idx,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << IDX_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we_lane[g]) begin
            mem[idx] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[idx];
   end

endmodule

// File: rtl/dram_dualcas_frontend.sv
module dram_dualcas_frontend
   import dram_fe_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int LANE_W      = 8,
   parameter int ROW_KEEP    = 2,
   parameter int COL_KEEP    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                lcas_n,
   input  logic                ucas_n,
   input  logic                we_n,
   input  logic                oe_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2*LANE_W-1:0] dq_in,
   output logic [2*LANE_W-1:0] dq_out,
   output logic [1:0]          dq_oe
);

   localparam int LANES  = 2;
   localparam int DQ_W   = LANES * LANE_W;
   localparam int IDX_W  = ROW_KEEP + COL_KEEP;
   localparam int SYNC_W = CTL_W + ADDR_W + DQ_W;
   localparam logic [SYNC_W-1:0] SYNC_RST = {{CTL_W{1'b1}}, {(ADDR_W+DQ_W){1'b0}}};

   if (ADDR_W < 1 || LANE_W < 1) begin : g_bad_width
      $error("dram_dualcas_frontend: widths must be positive");
   end
   if (ROW_KEEP < 0 || ROW_KEEP > ADDR_W) begin : g_bad_row
      $error("dram_dualcas_frontend: ROW_KEEP out of range");
   end
   if (COL_KEEP < 1 || COL_KEEP > ADDR_W) begin : g_bad_col
      $error("dram_dualcas_frontend: COL_KEEP out of range");
   end
   if (IDX_W > 12) begin : g_bad_depth
      $error("dram_dualcas_frontend: storage array too deep");
   end

   function automatic logic [ADDR_W-1:0] fold_bits(input logic [ADDR_W-1:0] v, input int k);
      logic [ADDR_W-1:0] r;
      r = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         r[i % k] = r[i % k] ^ v[i];
      end
      return r;
   endfunction

   ctl_pins_t          ctl_pin, s_ctl;
   logic [ADDR_W-1:0]  s_addr;
   logic [DQ_W-1:0]    s_dq;
   logic [LANES-1:0]   s_cas_n, p_cas_n;
   logic               s_ras_n, s_oe_n;

   assign ctl_pin = {ras_n, lcas_n, ucas_n, we_n, oe_n};

   dram_fe_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({ctl_pin, addr, dq_in}),
      .dout ({s_ctl, s_addr, s_dq})
   );

   assign s_ras_n = s_ctl.ras_n;
   assign s_oe_n  = s_ctl.oe_n;
   assign s_cas_n = {s_ctl.ucas_n, s_ctl.lcas_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_cas_n <= '1;
      else        p_cas_n <= s_cas_n;
   end

   logic              row_open, col_held, wr_q, wr_eff;
   logic [ADDR_W-1:0] row_q, col_q, col_eff;

   dram_fe_addr_latch #(
      .ADDR_W(ADDR_W),
      .LANES (LANES)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_ras_n (s_ras_n),
      .s_cas_n (s_cas_n),
      .s_we_n  (s_ctl.we_n),
      .s_addr  (s_addr),
      .row_open(row_open),
      .row_q   (row_q),
      .col_held(col_held),
      .col_q   (col_q),
      .wr_q    (wr_q),
      .col_eff (col_eff),
      .wr_eff  (wr_eff)
   );

   logic [IDX_W-1:0]  cell_idx;
   logic [ADDR_W-1:0] col_fold;

   assign col_fold = fold_bits(col_eff, COL_KEEP);

   if (ROW_KEEP == 0) begin : g_col_only
      logic unused_row;
      assign unused_row = ^row_q;
      assign cell_idx   = col_fold[COL_KEEP-1:0];
   end else begin : g_row_col
      logic [ADDR_W-1:0] row_fold;
      assign row_fold = fold_bits(row_q, ROW_KEEP);
      assign cell_idx = {row_fold[ROW_KEEP-1:0], col_fold[COL_KEEP-1:0]};
   end

   logic [DQ_W-1:0]  wdata_q, wr_data, rdata;
   logic [LANES-1:0] we_lane, rd_lane;
   logic             page_live;

   assign page_live = row_open & ~s_ras_n;
   assign wr_data   = col_held ? wdata_q : s_dq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane_ctl
      assign we_lane[g] = page_live & wr_eff & p_cas_n[g] & ~s_cas_n[g];
      assign rd_lane[g] = page_live & ~wr_eff & s_ctl.we_n & ~s_oe_n & ~s_cas_n[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
      end else if (page_live && !col_held && (|(~s_cas_n))) begin
         wdata_q <= s_dq;
      end
   end

   dram_fe_lane_store #(
      .LANES (LANES),
      .LANE_W(LANE_W),
      .IDX_W (IDX_W)
   ) u_store (
      .clk    (clk),
      .we_lane(we_lane),
      .idx    (cell_idx),
      .wdata  (wr_data),
      .rdata  (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_oe  <= '0;
         dq_out <= '0;
      end else begin
         dq_oe <= rd_lane;
         for (int i = 0; i < LANES; i++) begin
            dq_out[i*LANE_W +: LANE_W] <= rd_lane[i] ? rdata[i*LANE_W +: LANE_W] : '0;
         end
      end
   end

endmodule

// File: rtl/dram_dualcas_frontend_chk.sv
module dram_dualcas_frontend_chk #(
   parameter int ADDR_W = 9,
   parameter int LANE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                s_ras_n,
   input logic                s_oe_n,
   input logic [1:0]          s_cas_n,
   input logic                row_open,
   input logic [ADDR_W-1:0]   row_q,
   input logic                col_held,
   input logic [ADDR_W-1:0]   col_q,
   input logic                wr_q,
   input logic [1:0]          dq_oe,
   input logic [2*LANE_W-1:0] dq_out
);

   AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      row_open && $past(row_open) |-> $stable(row_q)); // R1

   AST_LOWER_NEEDS_LCAS: assert property (@(posedge clk) disable iff (!rst_n)
      s_cas_n[0] |=> !dq_oe[0]); // R2

   AST_UPPER_NEEDS_UCAS: assert property (@(posedge clk) disable iff (!rst_n)
      s_cas_n[1] |=> !dq_oe[1]); // R2

   AST_COL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      col_held && $past(col_held) |-> $stable(col_q)); // R4

   AST_EARLY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      col_held && wr_q |-> dq_oe == 2'b00); // R6

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      s_oe_n |=> dq_oe == 2'b00); // R7

   AST_RAS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      s_ras_n |=> (dq_oe == 2'b00) && (dq_out == '0) && !col_held); // R10

endmodule

bind dram_dualcas_frontend dram_dualcas_frontend_chk #(
   .ADDR_W(ADDR_W),
   .LANE_W(LANE_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_ras_n (s_ras_n),
   .s_oe_n  (s_oe_n),
   .s_cas_n (s_cas_n),
   .row_open(row_open),
   .row_q   (row_q),
   .col_held(col_held),
   .col_q   (col_q),
   .wr_q    (wr_q),
   .dq_oe   (dq_oe),
   .dq_out  (dq_out)
);

// File: tb/dram_dualcas_frontend_bench.sv
`timescale 1ns/1ps
module dram_dualcas_frontend_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic [8:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;

   int          n_checks = 0;
   int          n_fail   = 0;
   int          cyc      = 0;
   bit          done     = 1'b0;
   logic [15:0] model [64];

   always #2 clk = ~clk;

   dram_dualcas_frontend u_dram_dualcas_frontend (
      .clk   (clk),
      .rst_n (rst_n),
      .ras_n (ras_n),
      .lcas_n(lcas_n),
      .ucas_n(ucas_n),
      .we_n  (we_n),
      .oe_n  (oe_n),
      .addr  (addr),
      .dq_in (dq_in),
      .dq_out(dq_out),
      .dq_oe (dq_oe)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int r, input int c);
      return 16'(((r*16 + c) * 16'h0407) ^ 16'h5A3C);
   endfunction

   task automatic open_row(input int r);
      addr = 9'(r); settle();
      ras_n = 1'b0; settle();
   endtask

   task automatic close_row();
      lcas_n = 1'b1; ucas_n = 1'b1; settle();
      ras_n = 1'b1; settle();
      chk("R10 lanes quiet after row close", {14'b0, dq_oe}, 16'h0);
   endtask

   task automatic wr_cell(input int r, input int c, input logic [15:0] d, input logic [1:0] m);
      we_n = 1'b0; addr = 9'(c); dq_in = d; settle();
      lcas_n = ~m[0]; ucas_n = ~m[1]; settle();
      chk("R6 early write leaves lanes undriven", {14'b0, dq_oe}, 16'h0);
      lcas_n = 1'b1; ucas_n = 1'b1; settle();
      we_n = 1'b1;
      if (m[0]) model[r*16+c][7:0]  = d[7:0];
      if (m[1]) model[r*16+c][15:8] = d[15:8];
   endtask

   task automatic rd_cell(input int r, input int c, input logic [1:0] m, input string tag);
      logic [15:0] e;
      e = model[r*16+c] & {{8{m[1]}}, {8{m[0]}}};
      addr = 9'(c); settle();
      lcas_n = ~m[0]; ucas_n = ~m[1]; settle();
      chk({tag, " lane enables"}, {14'b0, dq_oe}, {14'b0, m});
      chk({tag, " data"}, dq_out, e);
      lcas_n = 1'b1; ucas_n = 1'b1; settle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R10 reset enables", {14'b0, dq_oe}, 16'h0);
      chk("R10 reset data", dq_out, 16'h0);
      rst_n = 1'b1; settle();

      // R1 R9: full-word page-mode writes across every row and column
      for (int r = 0; r < 4; r++) begin
         open_row(r);
         for (int c = 0; c < 16; c++) wr_cell(r, c, pat(r, c), 2'b11);
         close_row();
      end
      // R8: byte-masked overwrites, mask cycles with row+column
      for (int r = 0; r < 4; r++) begin
         open_row(r);
         for (int c = 0; c < 16; c++) begin
            logic [1:0] m;
            m = 2'((r + c) % 4);
            if (m != 2'b00) wr_cell(r, c, ~pat(r, c) ^ 16'(c << 8), m);
         end
         close_row();
      end
      // R1 R2 R5 R9: read back each cell, with single-lane reads mixed in
      for (int r = 0; r < 4; r++) begin
         open_row(r);
         for (int c = 0; c < 16; c++) begin
            rd_cell(r, c, 2'b11, "R9 R1 page read");
            if (c % 4 == 0) rd_cell(r, c, 2'b01, "R2 R5 lower lane only");
            if (c % 4 == 1) rd_cell(r, c, 2'b10, "R2 R5 upper lane only");
         end
         close_row();
      end

      // R3: transparent column follows the bus until first strobe
      open_row(0);
      addr = 9'd3; settle();
      addr = 9'd7; settle();
      lcas_n = 1'b0; settle();
      chk("R3 column taken at first strobe", dq_out, {8'h00, model[7][7:0]});
      // R4: lagging strobe reuses latched column despite address change
      addr = 9'd2; settle();
      ucas_n = 1'b0; settle();
      chk("R4 latched column reused", dq_out, model[7]);
      chk("R4 both lanes on", {14'b0, dq_oe}, 16'h3);
      lcas_n = 1'b1; ucas_n = 1'b1; settle();
      ucas_n = 1'b0; settle();
      chk("R4 new column after both high", dq_out, {model[2][15:8], 8'h00});
      ucas_n = 1'b1; settle();

      // R7: output enable and late write select gate the drive
      addr = 9'd5; oe_n = 1'b1; settle();
      lcas_n = 1'b0; ucas_n = 1'b0; settle();
      chk("R7 oe_n high blocks drive", {14'b0, dq_oe}, 16'h0);
      oe_n = 1'b0; settle();
      chk("R7 oe_n low drives", dq_out, model[5]);
      we_n = 1'b0; dq_in = 16'hFFFF; settle();
      chk("R7 we_n low blocks drive", {14'b0, dq_oe}, 16'h0);
      we_n = 1'b1; settle();
      lcas_n = 1'b1; ucas_n = 1'b1; settle();
      rd_cell(0, 5, 2'b11, "R7 late we_n wrote nothing");

      // R8: lagging lane receives data captured at the first strobe
      we_n = 1'b0; addr = 9'd9; dq_in = 16'hA55A; settle();
      lcas_n = 1'b0; settle();
      dq_in = 16'h3CC3; addr = 9'd11; settle();
      ucas_n = 1'b0; settle();
      chk("R6 R8 early write quiet", {14'b0, dq_oe}, 16'h0);
      lcas_n = 1'b1; ucas_n = 1'b1; settle();
      we_n = 1'b1;
      model[9] = 16'hA55A;
      rd_cell(0, 9, 2'b11, "R8 late lane used first-edge data");
      rd_cell(0, 11, 2'b11, "R8 other column untouched");

      // R10: row strobe rising ends drive even with strobes low
      addr = 9'd9; settle();
      lcas_n = 1'b0; ucas_n = 1'b0; settle();
      chk("R10 drive before close", {14'b0, dq_oe}, 16'h3);
      ras_n = 1'b1; settle();
      chk("R10 row close enables", {14'b0, dq_oe}, 16'h0);
      chk("R10 row close data", dq_out, 16'h0);
      lcas_n = 1'b1; ucas_n = 1'b1; settle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule